// File: doc/BRIEF.md
# Receive Character Queue with Error Tracking

This block sits between a serial receiver and a host-facing register file. Each character arriving from the receiver is stored with three per-character flags: a parity error, a framing error and a break indication. The host reads characters one at a time through the receive holding register. Every read removes the oldest stored character.

The block drives a line-status byte from registers. The byte shows the flags of the character now at the head of the queue, a data-ready bit, and a sticky overrun bit. It also carries a summary error bit, which stays high while any stored character still carries an error. A live count of erroneous entries drives the summary bit. The count goes up when a flagged character enters the queue and down when one leaves, so the summary bit drops in the same cycle as the last flagged character is read.

A flush input empties the queue. Serial deserialisation and interrupt generation sit outside this block.

Top module: `rxq_err_fifo`

## Requirements
- R1: The queue holds exactly DEPTH characters (64 by default). After 64 accepted writes into an empty queue, `fill` reads 64.
- R2: Characters leave in arrival order. `rhr_data` shows the data of the oldest entry one cycle after the write or read that made it the oldest. A pulse on `rhr_rd` advances to the next entry.
- R3: `lsr_q[2]` shows the head entry's parity flag, `lsr_q[3]` its framing flag and `lsr_q[4]` its break flag. These bits change to the new head's flags in the cycle after each read.
- R4: While the queue is empty, `lsr_q[4:2]` and `rhr_data` are zero.
- R5: `lsr_q[7]` is 1 while at least one stored entry has any of its three flags set. It returns to 0 in the cycle after the last such entry is read out.
- R6: A write that arrives while `fill` equals DEPTH is discarded and leaves the stored entries unchanged. It sets `lsr_q[1]` (overrun), even when a read happens in the same cycle.
- R7: A pulse on `lsr_rd` clears `lsr_q[1]`. If a new overrun arrives in the same cycle, the overrun bit stays set.
- R8: A write and a read in the same cycle on a non-empty, non-full queue leave `fill` unchanged. The error summary then accounts for both the entry that enters and the entry that leaves.
- R9: `lsr_q[0]` (data ready) is 1 exactly when `fill` is non-zero. `lsr_q[6:5]` are always 0.
- R10: A pulse on `flush` empties the queue and clears the error summary and the overrun bit in the next cycle. Any write or read in that same cycle is ignored.
- R11: A read of an empty queue has no effect. `fill` stays 0, and the next character written is the one shown at the head.
- R12: After reset, `fill`, `rhr_data` and `lsr_q` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empties the queue and clears the status |
| rx_wr | input | 1 | Receiver delivers one character |
| rx_byte | input | 8 | Received data |
| rx_par_err | input | 1 | Parity error flag of the character |
| rx_frm_err | input | 1 | Framing error flag of the character |
| rx_brk | input | 1 | Break flag of the character |
| rhr_rd | input | 1 | Host read of the holding register (pop) |
| lsr_rd | input | 1 | Host read of the line-status register |
| rhr_data | output | 8 | Data of the head entry |
| lsr_q | output | 8 | Line status: 0 ready, 1 overrun, 2 parity, 3 framing, 4 break, 7 error summary |
| fill | output | 7 | Number of stored entries |

## Verification
The hardest conditions to reach are the ones where the head is replaced by the character written in the same cycle. The first case is a write into an empty queue. The second is a simultaneous write and read with a single entry stored. In both cases the RAM read port still returns the old word, so the head must come from the bypass register. The bench drains the queue to one entry and then pulses `rx_wr` and `rhr_rd` together. It also fills all 64 entries to provoke overrun, including a same-cycle overrun and status read. The error summary is checked while flagged entries are popped past one by one.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rxq_ent_t;

  localparam int unsigned ENT_W = $bits(rxq_ent_t);

  function automatic logic ent_bad(input rxq_ent_t e);
    return e.brk | e.frm | e.par;
  endfunction
endpackage

// File: rtl/rxq_ram.sv
// Simple dual-port storage, registered read, read-before-write.
module rxq_ram #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 11,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxq_ptrs.sv
// Pointer and occupancy control. DEPTH must be a power of two.
module rxq_ptrs #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          full,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] raddr,
  output logic [LW-1:0] lvl,
  output logic          lvl_nz_nxt,
  output logic          head_from_wr
);
  logic [AW-1:0] rd_ptr;
  logic [LW-1:0] lvl_nxt;
  logic          empty;

  assign full    = (lvl == LW'(DEPTH));
  assign empty   = (lvl == '0);
  assign push_ok = push_req && !full && !flush;
  assign pop_ok  = pop_req && !empty && !flush;

  assign raddr   = pop_ok ? rd_ptr + AW'(1) : rd_ptr;
  assign lvl_nxt = flush ? '0 : lvl + LW'(push_ok) - LW'(pop_ok);
  assign lvl_nz_nxt = (lvl_nxt != '0);
  // The entry written this cycle becomes the head: RAM cannot return it yet.
  assign head_from_wr = push_ok && (empty || (pop_ok && lvl == LW'(1)));

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      lvl    <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      rd_ptr <= raddr;
      lvl    <= lvl_nxt;
    end
  end
endmodule

// File: rtl/rxq_errcnt.sv
// Counts stored entries that carry any error flag.
module rxq_errcnt #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic inc,
  input  logic dec,
  output logic any_q
);
  logic [LW-1:0] cnt;
  logic [LW-1:0] cnt_nxt;

  assign cnt_nxt = flush ? '0 : cnt + LW'(inc) - LW'(dec);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      any_q <= 1'b0;
    end else begin
      cnt   <= cnt_nxt;
      any_q <= (cnt_nxt != '0);
    end
  end
endmodule

// File: rtl/rxq_head.sv
// Head-of-queue view: RAM output, or the bypass copy for a fresh write.
module rxq_head
  import rxq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     flush,
  input  logic     push_ok,
  input  rxq_ent_t wr_ent,
  input  logic     head_from_wr,
  input  logic     lvl_nz_nxt,
  input  rxq_ent_t ram_q,
  output rxq_ent_t head
);
  rxq_ent_t byp_q;
  logic     sel_byp;
  logic     vld;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld     <= 1'b0;
      sel_byp <= 1'b0;
      byp_q   <= '0;
    end else begin
      vld     <= lvl_nz_nxt;
      sel_byp <= head_from_wr;
      if (push_ok) byp_q <= wr_ent;
    end
  end

  assign head = !vld ? '0 : (sel_byp ? byp_q : ram_q);
endmodule

// File: rtl/rxq_err_fifo.sv
module rxq_err_fifo
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              rx_wr,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_par_err,
  input  logic              rx_frm_err,
  input  logic              rx_brk,
  input  logic              rhr_rd,
  input  logic              lsr_rd,
  output logic [DATA_W-1:0] rhr_data,
  output logic [7:0]        lsr_q,
  output logic [LW-1:0]     fill
);
  rxq_ent_t      wr_ent, ram_q, head;
  logic          push_ok, pop_ok, full, lvl_nz_nxt, head_from_wr;
  logic [AW-1:0] wr_ptr, raddr;
  logic          err_any, ovr_q;
  logic [ENT_W-1:0] ram_rdata;

  assign wr_ent = '{brk: rx_brk, frm: rx_frm_err, par: rx_par_err, data: rx_byte};

  rxq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .flush(flush),
    .push_req(rx_wr), .pop_req(rhr_rd),
    .push_ok(push_ok), .pop_ok(pop_ok), .full(full),
    .wr_ptr(wr_ptr), .raddr(raddr), .lvl(fill),
    .lvl_nz_nxt(lvl_nz_nxt), .head_from_wr(head_from_wr)
  );

  rxq_ram #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_ram (
    .clk(clk), .we(push_ok), .waddr(wr_ptr), .wdata(wr_ent),
    .raddr(raddr), .rdata(ram_rdata)
  );
  assign ram_q = rxq_ent_t'(ram_rdata);

  rxq_head u_head (
    .clk(clk), .rst(rst), .flush(flush), .push_ok(push_ok), .wr_ent(wr_ent),
    .head_from_wr(head_from_wr), .lvl_nz_nxt(lvl_nz_nxt),
    .ram_q(ram_q), .head(head)
  );

  rxq_errcnt #(.DEPTH(DEPTH)) u_errcnt (
    .clk(clk), .rst(rst), .flush(flush),
    .inc(push_ok && ent_bad(wr_ent)),
    .dec(pop_ok && ent_bad(head)),
    .any_q(err_any)
  );

  // Overrun: a new overrun wins over a clearing status read.
  always_ff @(posedge clk) begin
    if (rst || flush)            ovr_q <= 1'b0;
    else if (rx_wr && full)      ovr_q <= 1'b1;
    else if (lsr_rd)             ovr_q <= 1'b0;
  end

  assign rhr_data = head.data;
  assign lsr_q = {err_any, 2'b00, head.brk, head.frm, head.par, ovr_q, (fill != '0)};
endmodule

// File: rtl/rxq_err_fifo_chk.sv
module rxq_err_fifo_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          flush,
  input logic          rx_wr,
  input logic          rhr_rd,
  input logic          lsr_rd,
  input logic [7:0]    rhr_data,
  input logic [7:0]    lsr_q,
  input logic [LW-1:0] fill
);
  p_fill_bound_r1: assert property (@(posedge clk) disable iff (rst)
    fill <= LW'(DEPTH));

  p_empty_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (fill == '0) |-> (lsr_q[4:2] == 3'b000 && rhr_data == 8'h00));

  p_head_err_sum_r5: assert property (@(posedge clk) disable iff (rst)
    (lsr_q[4:2] != 3'b000) |-> lsr_q[7]);

  p_full_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_wr && fill == LW'(DEPTH) && !rhr_rd && !flush) |=> (fill == LW'(DEPTH) && lsr_q[1]));

  p_ovr_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !flush && !(rx_wr && fill == LW'(DEPTH))) |=> !lsr_q[1]);

  p_same_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_wr && rhr_rd && !flush && fill != '0 && fill != LW'(DEPTH)) |=> $stable(fill));

  p_ready_r9: assert property (@(posedge clk) disable iff (rst)
    lsr_q[0] == (fill != '0) && lsr_q[6:5] == 2'b00);

  p_flush_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (fill == '0 && lsr_q == 8'h00));

  p_empty_pop_r11: assert property (@(posedge clk) disable iff (rst)
    (fill == '0 && !rx_wr && !flush) |=> (fill == '0));
endmodule

bind rxq_err_fifo rxq_err_fifo_chk #(.DEPTH(DEPTH)) i_chk (.*);

// File: tb/test_rxq_err_fifo.sv
module test_rxq_err_fifo;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       flush = 1'b0;
  logic       rx_wr = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       rx_par_err = 1'b0, rx_frm_err = 1'b0, rx_brk = 1'b0;
  logic       rhr_rd = 1'b0, lsr_rd = 1'b0;
  logic [7:0] rhr_data, lsr_q;
  logic [6:0] fill;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rxq_err_fifo #(.DEPTH(DEPTH)) i_rxq_err_fifo (
    .clk(clk), .rst(rst), .flush(flush), .rx_wr(rx_wr), .rx_byte(rx_byte),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk),
    .rhr_rd(rhr_rd), .lsr_rd(lsr_rd), .rhr_data(rhr_data), .lsr_q(lsr_q), .fill(fill)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    rx_wr = 0; rhr_rd = 0; lsr_rd = 0; flush = 0;
    rx_par_err = 0; rx_frm_err = 0; rx_brk = 0;
  endtask

  // flags: {brk, frm, par}
  task automatic set_wr(input logic [7:0] b, input logic [2:0] fl);
    rx_wr = 1; rx_byte = b; {rx_brk, rx_frm_err, rx_par_err} = fl;
  endtask

  task automatic push(input logic [7:0] b, input logic [2:0] fl);
    set_wr(b, fl); tick();
  endtask

  task automatic pop();
    rhr_rd = 1; tick();
  endtask

  task automatic t_reset_r12();
    chk("R12 fill", int'(fill), 0);
    chk("R12 lsr", int'(lsr_q), 0);
    chk("R12 data", int'(rhr_data), 0);
  endtask

  task automatic t_order_r2();
    push(8'h11, 3'b000);
    chk("R9 ready", int'(lsr_q[0]), 1);
    chk("R2 head", int'(rhr_data), 'h11);
    push(8'h22, 3'b000); push(8'h33, 3'b000);
    chk("R2 fill", int'(fill), 3);
    pop(); chk("R2 second", int'(rhr_data), 'h22);
    pop(); chk("R2 third", int'(rhr_data), 'h33);
    pop(); chk("R4 empty lsr", int'(lsr_q), 0);
  endtask

  task automatic t_flags_r3_r5();
    push(8'hA0, 3'b000); push(8'hA1, 3'b001); push(8'hA2, 3'b010);
    push(8'hA3, 3'b100); push(8'hA4, 3'b000);
    chk("R3 clean head", int'(lsr_q[4:2]), 0);
    chk("R5 summary set", int'(lsr_q[7]), 1);
    pop(); chk("R3 parity head", int'(lsr_q[4:2]), 3'b001);
    pop(); chk("R3 framing head", int'(lsr_q[4:2]), 3'b010);
    pop(); chk("R3 break head", int'(lsr_q[4:2]), 3'b100);
    chk("R5 summary held", int'(lsr_q[7]), 1);
    pop(); chk("R5 summary dropped", int'(lsr_q[7]), 0);
    chk("R3 data", int'(rhr_data), 'hA4);
    pop(); chk("R4 empty", int'({lsr_q[4:2], rhr_data}), 0);
  endtask

  task automatic t_full_r1_r6_r7();
    for (int i = 0; i < DEPTH; i++) push(8'(i), (i == DEPTH - 1) ? 3'b001 : 3'b000);
    chk("R1 fill full", int'(fill), DEPTH);
    push(8'hEE, 3'b100);
    chk("R6 overrun set", int'(lsr_q[1]), 1);
    chk("R6 fill kept", int'(fill), DEPTH);
    lsr_rd = 1; tick();
    chk("R7 overrun cleared", int'(lsr_q[1]), 0);
    set_wr(8'hEF, 3'b000); lsr_rd = 1; tick();
    chk("R7 set wins", int'(lsr_q[1]), 1);
    set_wr(8'hF0, 3'b000); rhr_rd = 1; tick();
    chk("R6 overrun with pop", int'(lsr_q[1]), 1);
    chk("R6 drop with pop", int'(fill), DEPTH - 1);
    lsr_rd = 1; tick();
    for (int i = 1; i < DEPTH; i++) begin
      if (rhr_data != 8'(i)) chk("R6 preserved", int'(rhr_data), i);
      else n_chk++;
      pop();
    end
    chk("R5 summary cleared", int'(lsr_q), 0);
  endtask

  task automatic t_simul_r8();
    push(8'h51, 3'b010); push(8'h52, 3'b000);
    set_wr(8'h53, 3'b000); rhr_rd = 1; tick();
    chk("R8 fill", int'(fill), 2);
    chk("R8 summary off", int'(lsr_q[7]), 0);
    set_wr(8'h54, 3'b001); rhr_rd = 1; tick();
    chk("R8 head", int'(rhr_data), 'h53);
    chk("R8 summary on", int'(lsr_q[7]), 1);
    pop();
    set_wr(8'h55, 3'b100); rhr_rd = 1; tick();
    chk("R8 single bypass", int'({lsr_q[4:2], rhr_data}), {3'b100, 8'h55});
    chk("R8 single fill", int'(fill), 1);
    pop();
    chk("R8 drained", int'(lsr_q), 0);
  endtask

  task automatic t_empty_pop_r11();
    pop();
    chk("R11 fill", int'(fill), 0);
    push(8'h6A, 3'b000);
    chk("R11 head", int'(rhr_data), 'h6A);
    pop();
  endtask

  task automatic t_flush_r10();
    for (int i = 0; i < DEPTH + 1; i++) push(8'(i + 3), 3'b010);
    flush = 1; set_wr(8'h77, 3'b000); tick();
    chk("R10 fill", int'(fill), 0);
    chk("R10 lsr", int'(lsr_q), 0);
    push(8'h5A, 3'b000);
    chk("R10 after flush", int'({lsr_q, rhr_data}), {8'h01, 8'h5A});
    pop();
  endtask

  initial begin
    #20_000_000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset_r12();
    t_order_r2();
    t_flags_r3_r5();
    t_full_r1_r6_r7();
    t_simul_r8();
    t_empty_pop_r11();
    t_flush_r10();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule